// File: doc/BRIEF.md
# Dual-Path Registered Bus Transceiver

This block couples two parallel data ports, A and B, through one storage word per direction. The A-to-B word drives port B and the B-to-A word drives port A. Each word has three controls: a latch enable, a strobe and a drive enable. While the latch enable is high, the word follows its source port on every system clock. While the latch enable is low, the word holds its value, except when its strobe falls from high to low; then it takes a new copy of the source port.

All controls are sampled on a fast system clock. A strobe falling edge is a sample of 1 followed by a sample of 0. Each port comes out as a data bus plus a one-bit drive enable, so the block fits a synthesizable flow without bidirectional nets. The A-to-B drive enable is active high. The B-to-A drive enable is active low.

Top module: `dual_path_xcvr`

## Requirements
- R1: A synchronous active-low reset (`rstN` low at a clock edge) clears both stored words. After that edge, `portBOut` and `portAOut` read 0.
- R2: If `latAb` is 1 at a clock edge, the A-to-B word takes `portAIn`. The captured value appears on `portBOut` after that edge.
- R3: If `latAb` is 0 at an edge and `strbAb` has no falling edge there, `portBOut` keeps its value.
- R4: If `latAb` is 0 and `strbAb` was 1 at the previous edge and is 0 at this edge, the word takes `portAIn` at this edge.
- R5: When `latAb` drops to 0 while `strbAb` is low, `portBOut` keeps the last transparent value. Nothing is captured until the next 1-to-0 strobe transition.
- R6: `portBDrive` equals `enAb` (active high), whatever the data, latch enable and strobe do. `portBOut` keeps showing the stored word when the drive enable is off.
- R7: `portADrive` is the inverse of `enBaN` (active low), whatever the other inputs do.
- R8: The B-to-A word follows R2 to R5 with `portBIn`, `latBa` and `strbBa`, and drives `portAOut`.
- R9: Reset records both strobes as previously low. A strobe that is high during reset and low at the first edge after reset captures nothing.
- R10: The two directions are independent. Activity on one path never changes the other path's word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control |
| rstN | input | 1 | Synchronous reset, active low |
| portAIn | input | WIDTH (18) | Data seen on port A, source for the A-to-B word |
| portBIn | input | WIDTH (18) | Data seen on port B, source for the B-to-A word |
| enAb | input | 1 | Port B drive enable, active high |
| latAb | input | 1 | A-to-B latch enable, transparent when high |
| strbAb | input | 1 | A-to-B strobe, captures on its falling edge |
| enBaN | input | 1 | Port A drive enable, active low |
| latBa | input | 1 | B-to-A latch enable |
| strbBa | input | 1 | B-to-A strobe, captures on its falling edge |
| portBOut | output | WIDTH (18) | A-to-B stored word |
| portBDrive | output | 1 | Port B driver enable |
| portAOut | output | WIDTH (18) | B-to-A stored word |
| portADrive | output | 1 | Port A driver enable |

## Verification
Each direction has two write causes, the transparent latch enable and the detected strobe fall, and both can occur in the same system cycle. A latch enable can also drop in the very cycle its strobe falls. Random stimulus keeps the latch enables mostly low and toggles the strobes often, so these coincidences occur many times. Directed sequences add the drop-while-low case and the out-of-reset case. Every output is compared each cycle with a bench model built from the requirements. That model writes the word once when either cause holds, and it treats a fall in the same cycle as the latch-enable drop as a capture.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DEF_WIDTH = 18;

  // Write strobes from the control unit to the storage datapath
  typedef struct packed {
    logic loadAb;
    logic loadBa;
  } xcvr_strobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         latAb,
  input  logic         strbAb,
  input  logic         latBa,
  input  logic         strbBa,
  output xcvr_strobe_t strobes
);
  localparam int unsigned NPATH = 2;

  logic [NPATH-1:0] latVec;
  logic [NPATH-1:0] strbVec;
  logic [NPATH-1:0] strbPrev;
  logic [NPATH-1:0] loadVec;

  assign latVec  = {latBa, latAb};
  assign strbVec = {strbBa, strbAb};

  // Previous strobe samples; reset records them as low
  always_ff @(posedge clk) begin
    if (!rstN) strbPrev <= '0;
    else       strbPrev <= strbVec;
  end

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic fallSeen;
    assign fallSeen   = strbPrev[p] & ~strbVec[p];
    assign loadVec[p] = rstN & (latVec[p] | fallSeen);
  end

  assign strobes.loadAb = loadVec[0];
  assign strobes.loadBa = loadVec[1];
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  xcvr_strobe_t     strobes,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] wordAb,
  output logic [WIDTH-1:0] wordBa
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAb <= '0;
      wordBa <= '0;
    end else begin
      if (strobes.loadAb) wordAb <= srcA;
      if (strobes.loadBa) wordBa <= srcB;
    end
  end
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] portAIn,
  input  logic [WIDTH-1:0] portBIn,
  input  logic             enAb,
  input  logic             latAb,
  input  logic             strbAb,
  input  logic             enBaN,
  input  logic             latBa,
  input  logic             strbBa,
  output logic [WIDTH-1:0] portBOut,
  output logic             portBDrive,
  output logic [WIDTH-1:0] portAOut,
  output logic             portADrive
);
  xcvr_strobe_t strobes;

  xcvr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .latAb   (latAb),
    .strbAb  (strbAb),
    .latBa   (latBa),
    .strbBa  (strbBa),
    .strobes (strobes)
  );

  xcvr_store #(.WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcA    (portAIn),
    .srcB    (portBIn),
    .wordAb  (portBOut),
    .wordBa  (portAOut)
  );

  assign portBDrive = enAb;
  assign portADrive = ~enBaN;
endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
  parameter int unsigned WIDTH = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] portAIn,
  input logic [WIDTH-1:0] portBIn,
  input logic             enAb,
  input logic             latAb,
  input logic             strbAb,
  input logic             enBaN,
  input logic             latBa,
  input logic             strbBa,
  input logic [WIDTH-1:0] portBOut,
  input logic             portBDrive,
  input logic [WIDTH-1:0] portAOut,
  input logic             portADrive
);
  // R2
  ab_transparent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && latAb) |=> (portBOut == $past(portAIn)));

  // R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !latAb && !($past(strbAb) && !strbAb)) |=> $stable(portBOut));

  // R4
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !latAb && $past(strbAb) && !strbAb) |=> (portBOut == $past(portAIn)));

  // R8
  ba_transparent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && latBa) |=> (portAOut == $past(portBIn)));

  // R8
  ba_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !latBa && $past(strbBa) && !strbBa) |=> (portAOut == $past(portBIn)));

  // R6
  b_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    portBDrive == enAb);

  // R7
  a_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    portADrive != enBaN);
endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_path_xcvr_tb.sv
module dual_path_xcvr_tb;
  localparam int unsigned W = 18;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] portAIn = '0, portBIn = '0;
  logic         enAb = 1'b0, latAb = 1'b0, strbAb = 1'b0;
  logic         enBaN = 1'b1, latBa = 1'b0, strbBa = 1'b0;
  logic [W-1:0] portBOut, portAOut;
  logic         portBDrive, portADrive;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_path_xcvr #(.WIDTH(W)) u_dut (.*);

  // Reference model
  logic [W-1:0] mB = '0, mA = '0;
  logic         pAb = 1'b0, pBa = 1'b0, lastLatAb = 1'b0, lastLatBa = 1'b0;
  string        tagB = "R1", tagA = "R1";

  function automatic string tagFor(input bit rst, input bit lat, input bit fall,
                                   input bit lastLat, input bit strb, input bit isBa);
    if (!rst) return "R1";
    if (lat) return isBa ? "R8" : "R2";
    if (fall) return isBa ? "R8" : "R4";
    if (lastLat && !strb) return isBa ? "R8" : "R5";
    return isBa ? "R8" : "R3";
  endfunction

  always @(posedge clk) begin
    tagB <= tagFor(rstN, latAb, pAb && !strbAb, lastLatAb, strbAb, 1'b0);
    tagA <= tagFor(rstN, latBa, pBa && !strbBa, lastLatBa, strbBa, 1'b1);
    if (!rstN) begin
      mB <= '0; mA <= '0; pAb <= 1'b0; pBa <= 1'b0;
    end else begin
      if (latAb || (pAb && !strbAb)) mB <= portAIn;
      if (latBa || (pBa && !strbBa)) mA <= portBIn;
      pAb <= strbAb; pBa <= strbBa;
    end
    lastLatAb <= latAb; lastLatBa <= latBa;
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOuts();
    check(tagB, portBOut, mB);
    check({tagA, " R10"}, portAOut, mA);
  endtask

  task automatic drive(input bit r, input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit eab, input bit lab, input bit sab,
                       input bit eba, input bit lba, input bit sba);
    @(negedge clk);
    checkOuts();
    rstN = r; portAIn = a; portBIn = b;
    enAb = eab; latAb = lab; strbAb = sab;
    enBaN = eba; latBa = lba; strbBa = sba;
    #1;
    check("R6", {{(W-1){1'b0}}, portBDrive}, {{(W-1){1'b0}}, eab});
    check("R7", {{(W-1){1'b0}}, portADrive}, {{(W-1){1'b0}}, !eba});
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R9: strobes high during reset, low right after
    repeat (3) drive(0, 18'h3ffff, 18'h2aaaa, 1, 0, 1, 0, 0, 1);
    drive(1, 18'h12345, 18'h0abcd, 1, 0, 0, 0, 0, 0);
    drive(1, 18'h11111, 18'h22222, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R9", portBOut, '0);
    check("R9", portAOut, '0);
    // R5: transparent, then latch drops with strobe low
    drive(1, 18'h1beef, 18'h0cafe, 0, 1, 0, 1, 1, 0);
    drive(1, 18'h05555, 18'h30303, 0, 0, 0, 1, 0, 0);
    drive(1, 18'h07777, 18'h01010, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    check("R5", portBOut, 18'h1beef);
    check("R5", portAOut, 18'h0cafe);
    // R4: strobe high then low, captured on the fall
    drive(1, 18'h00f0f, 18'h0f0f0, 1, 0, 1, 0, 0, 1);
    drive(1, 18'h2d2d2, 18'h1e1e1, 1, 0, 0, 0, 0, 0);
    drive(1, 18'h00001, 18'h00002, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R4", portBOut, 18'h2d2d2);
    check("R8", portAOut, 18'h1e1e1);
    // R6: drive off, stored word still visible
    drive(1, 18'h3c3c3, 18'h0, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    check("R6", portBOut, 18'h2d2d2);
    // Latch drops in the same cycle the strobe falls
    drive(1, 18'h11aa1, 18'h22bb2, 1, 1, 1, 0, 1, 1);
    drive(1, 18'h13579, 18'h2468a, 1, 0, 0, 0, 0, 0);
    drive(1, 18'h0, 18'h0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R4", portBOut, 18'h13579);
    check("R8", portAOut, 18'h2468a);
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 64) != 0, W'($urandom), W'($urandom),
            $urandom % 2, ($urandom % 4) == 0, $urandom % 2,
            $urandom % 2, ($urandom % 4) == 0, $urandom % 2);
    end
    drive(1, '0, '0, 0, 0, 0, 1, 0, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule